// File: doc/BRIEF.md
# Lockable Windowed Watchdog Timer

This block is a watchdog for a small microcontroller-style system. A slow-clock enable pulse, already in the system clock domain, is divided by a prescaler. Each prescaler tick moves a 12-bit down-counter one step. Software has to restart the counter with a keyed command before it runs out. If it runs out, or if a restart arrives too early, the block pulses one of two reset outputs: one for the whole system, one for the processor alone.

Configuration is held in a setup register that accepts exactly one write after reset. Early boot code can therefore fix the timeout, the early-restart window, the reset routing, the debug-halt behaviour and a global off switch for good. A status register keeps sticky flags for a counter run-out and for a restart that came too early. Reading the status register clears both flags.

Bus access is a simple strobe interface. A write takes effect on the clock edge where `bus_wr` is high. Read data is registered and is valid one cycle after `bus_rd`. Register offsets are: 0x0 command (write-only), 0x4 setup (read/write, locks after its first write), 0x8 status (read-only).

Top module: `wdt_timer`

## Requirements
- R1: After reset both reset outputs are low, status reads 0, and the setup register reads 0x0FFF1FFF. In this value the timeout is 0xFFF, the window is 0xFFF, reset routing is on, the processor-only select is clear, the off switch is clear and debug halt is clear.
- R2: Setup register field layout. Bits [11:0] hold the timeout in ticks. Bit 12 enables the reset outputs. Bit 13 routes the reset to the processor only. Bit 14 is the off switch. Bit 15 enables debug halt. Bits [27:16] hold the window value. Only the first write after reset is stored. Every later write is ignored, and the register reads back the first value written.
- R3: One tick occurs every DIV (128) slow-clock enables. After a setup write, or after an accepted restart, the counter holds the timeout T. Run-out happens on the (T+1)-th tick, and the counter then reloads T.
- R4: A write to offset 0x0 whose bits [31:24] equal 0xA5 and whose bit 0 is 1 is a restart. An accepted restart reloads the counter and clears the prescaler.
- R5: A command write with any other key, or with bit 0 clear, has no effect.
- R6: While the off switch is set, the counter does not run, restarts are ignored, no status flag is set and neither reset output ever rises.
- R7: If the reset enable bit is clear, a run-out still sets status bit 0, but neither reset output rises.
- R8: A fault pulses `wdt_rst_sys` when the processor-only select is clear. It pulses `wdt_rst_cpu` when that select is set. The other output stays low.
- R9: With debug halt enabled, the counter and the prescaler freeze while `dbg_halt` is high, and counting resumes when it falls.
- R10: A restart is accepted only while the counter is less than or equal to the window value, so a window of 0xFFF accepts restarts at any time. A restart that arrives while the counter is above the window is ignored. It sets status bit 1 and causes the same reset pulse as a run-out.
- R11: Each reset pulse stays high for exactly PULSE_LEN (16) system clocks.
- R12: Status bit 0 is the sticky run-out flag and bit 1 is the sticky early-restart flag. A read of offset 0x8 returns both flags and clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| dbg_halt | input | 1 | Debug halt request from the debugger |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after the read strobe |
| wdt_rst_sys | output | 1 | Whole-system reset pulse |
| wdt_rst_cpu | output | 1 | Processor-only reset pulse |

## Verification
The run-out path is tried with several timeout values and both reset routings. The measured delay separates a correct tick count (T+1 ticks) from an off-by-one counter. The choice of output that rises shows whether the routing select is decoded.

Restart streams are tried in three forms: well keyed, keyed wrong or with the restart bit clear, and timed inside or outside a narrow window. These separate key decoding from window checking. The off switch, the cleared reset enable and the debug halt are each held against a timeout that would otherwise expire, so a missing gate shows up as an unexpected pulse or status flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W  = 12;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int KEY_W  = 8;

  localparam logic [KEY_W-1:0]  CMD_KEY  = 8'hA5;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_STAT = 4'h8;

  // Setup register image, MSB first: window, halt, off, cpu-only, reset enable, timeout
  typedef struct packed {
    logic [CNT_W-1:0] window;
    logic             halt_en;
    logic             off;
    logic             cpu_only;
    logic             rst_en;
    logic [CNT_W-1:0] timeout;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  localparam cfg_t CFG_RESET = '{window: '1, halt_en: 1'b0, off: 1'b0,
                                 cpu_only: 1'b0, rst_en: 1'b1, timeout: '1};
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic slow_tick,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pcnt <= '0;
    end else if (run && slow_tick) begin
      pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
    end
  end

  assign tick = run && slow_tick && (pcnt == LAST);

  p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(pcnt));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             restart,
  input  logic             tick,
  input  logic             off,
  input  logic [CNT_W-1:0] timeout,
  input  logic [CNT_W-1:0] window,
  output logic             reload,
  output logic             uf_q,
  output logic             err_q
);
  logic [CNT_W-1:0] cnt;
  logic             restart_ok;
  logic             restart_bad;

  assign restart_ok  = restart && !off && (cnt <= window);
  assign restart_bad = restart && !off && (cnt >  window);
  assign reload      = load || restart_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '1;
      uf_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      uf_q  <= 1'b0;
      err_q <= 1'b0;
      if (reload) begin
        cnt <= timeout;
      end else if (restart_bad) begin
        err_q <= 1'b1;
      end else if (tick) begin
        if (cnt == '0) begin
          cnt  <= timeout;
          uf_q <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  p_runout_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
    uf_q |-> $past(cnt) == '0);
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load && !restart) |=> $stable(cnt));
  p_off_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (off && $past(off)) |-> (!uf_q && !err_q));
  p_early_only_r10: assert property (@(posedge clk) disable iff (rst)
    err_q |-> ($past(cnt) > $past(window)));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pulse_o
);
  localparam int LW = $clog2(LEN + 1);
  localparam logic [LW-1:0] LOADV = LW'(LEN - 1);

  logic [LW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      pulse_o <= 1'b0;
    end else if (start) begin
      remain  <= LOADV;
      pulse_o <= 1'b1;
    end else if (remain != '0) begin
      remain  <= remain - 1'b1;
      pulse_o <= 1'b1;
    end else begin
      pulse_o <= 1'b0;
    end
  end

  p_pulse_holds_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |=> pulse_o);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int DIV       = 128,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              dbg_halt,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_sys,
  output logic              wdt_rst_cpu
);
  cfg_t cfg_q;
  logic locked;
  logic cfg_load_q;
  logic uf_flag, err_flag;

  logic wr_cmd, wr_cfg, rd_stat, restart;
  logic run, tick, reload, uf, err, fault;
  logic [1:0] start_v, out_v;

  assign wr_cmd  = bus_wr && (bus_addr == OFF_CMD);
  assign restart = wr_cmd && (bus_wdata[DATA_W-1 -: KEY_W] == CMD_KEY) && bus_wdata[0];
  assign wr_cfg  = bus_wr && (bus_addr == OFF_CFG) && !locked;
  assign rd_stat = bus_rd && (bus_addr == OFF_STAT);
  assign run     = !cfg_q.off && !(cfg_q.halt_en && dbg_halt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= CFG_RESET;
      locked     <= 1'b0;
      cfg_load_q <= 1'b0;
    end else begin
      cfg_load_q <= wr_cfg;
      if (wr_cfg) begin
        cfg_q  <= cfg_t'(bus_wdata[CFG_W-1:0]);
        locked <= 1'b1;
      end
    end
  end

  wdt_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .clr(reload), .run(run),
    .slow_tick(slow_tick), .tick(tick)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst(rst), .load(cfg_load_q), .restart(restart),
    .tick(tick), .off(cfg_q.off), .timeout(cfg_q.timeout),
    .window(cfg_q.window), .reload(reload), .uf_q(uf), .err_q(err)
  );

  assign fault      = uf || err;
  assign start_v[0] = fault && cfg_q.rst_en && !cfg_q.cpu_only;
  assign start_v[1] = fault && cfg_q.rst_en &&  cfg_q.cpu_only;

  for (genvar g = 0; g < 2; g++) begin : g_out
    wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst(rst), .start(start_v[g]), .pulse_o(out_v[g])
    );
  end

  assign wdt_rst_sys = out_v[0];
  assign wdt_rst_cpu = out_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      uf_flag   <= 1'b0;
      err_flag  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      uf_flag  <= uf  || (uf_flag  && !rd_stat);
      err_flag <= err || (err_flag && !rd_stat);
      if (bus_rd) begin
        case (bus_addr)
          OFF_CFG:  bus_rdata <= {{(DATA_W-CFG_W){1'b0}}, cfg_q};
          OFF_STAT: bus_rdata <= {{(DATA_W-2){1'b0}}, err_flag, uf_flag};
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (rst)
    (locked && bus_wr && bus_addr == OFF_CFG) |=> $stable(cfg_q));
  p_stat_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !uf && !err) |=> (!uf_flag && !err_flag));
  p_bad_key_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !restart && !cfg_load_q) |-> !reload);
  p_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.rst_en && $past(!cfg_q.rst_en)) |-> !start_v[0] && !start_v[1]);
endmodule

// File: tb/wdt_timer_tb.sv
module wdt_timer_tb;
  localparam int DIV = 128;
  localparam int PLEN = 16;
  localparam int NV = 4;
  localparam logic [31:0] V_CFG [NV] = '{32'h0FFF_1000, 32'h0FFF_1002,
                                          32'h0FFF_3005, 32'h0FFF_3001};
  localparam bit V_CPU [NV] = '{1'b0, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0, rst = 1'b1, slow_tick = 1'b1, dbg_halt = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic wdt_rst_sys, wdt_rst_cpu;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit saw = 1'b0;

  always #2 clk = ~clk;

  wdt_timer #(.DIV(DIV), .PULSE_LEN(PLEN)) u_dut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .dbg_halt(dbg_halt),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_sys(wdt_rst_sys), .wdt_rst_cpu(wdt_rst_cpu)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (wdt_rst_sys || wdt_rst_cpu) saw <= 1'b1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; dbg_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; saw = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_fault(input int max, output int n);
    n = 0;
    while (!(wdt_rst_sys || wdt_rst_cpu) && n < max) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    logic [31:0] d;
    int n, w, lo;
    bit was_cpu;

    do_reset();
    // R1: reset state
    check(!wdt_rst_sys && !wdt_rst_cpu, "R1 outputs", {wdt_rst_cpu, wdt_rst_sys}, 0);
    rd(4'h8, d); check(d == 0, "R1 status", d, 0);
    rd(4'h4, d); check(d == 32'h0FFF_1FFF, "R1 setup", d, 32'h0FFF_1FFF);

    // R3 / R8 / R11 / R12: vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(4'h4, V_CFG[i]);
      lo = (int'(V_CFG[i][11:0]) + 1) * DIV;
      wait_fault(lo + 50, n);
      check(n >= lo && n <= lo + 8, "R3 run-out delay", n, lo);
      was_cpu = wdt_rst_cpu;
      check(wdt_rst_cpu == V_CPU[i] && wdt_rst_sys == !V_CPU[i], "R8 routing",
            {wdt_rst_cpu, wdt_rst_sys}, {V_CPU[i], !V_CPU[i]});
      w = 0;
      while ((wdt_rst_sys || wdt_rst_cpu) && w < 40) begin
        if (wdt_rst_cpu != was_cpu) w = 100;
        @(negedge clk); w++;
      end
      check(w == PLEN, "R11 pulse width", w, PLEN);
      rd(4'h8, d); check(d == 1, "R12 status run-out", d, 1);
      rd(4'h8, d); check(d == 0, "R12 cleared by read", d, 0);
    end

    // R2: write-once
    do_reset();
    wr(4'h4, 32'h0FFF_1003);
    rd(4'h4, d); check(d == 32'h0FFF_1003, "R2 first write", d, 32'h0FFF_1003);
    wr(4'h4, 32'h0000_4001);
    rd(4'h4, d); check(d == 32'h0FFF_1003, "R2 second write ignored", d, 32'h0FFF_1003);

    // R4: keyed restarts keep it alive (T=3, window max)
    saw = 1'b0;
    for (int k = 0; k < 8; k++) begin
      wr(4'h0, 32'hA500_0001);
      repeat (300) @(negedge clk);
    end
    check(!saw, "R4 restarts hold off reset", saw, 0);
    rd(4'h8, d); check(d == 0, "R4 status", d, 0);

    // R5: wrong key and missing restart bit do nothing
    wr(4'h0, 32'hA500_0001);
    saw = 1'b0; n = 0;
    for (int k = 0; k < 4; k++) begin
      repeat (100) @(negedge clk);
      wr(4'h0, (k % 2 == 0) ? 32'h5A00_0001 : 32'hA500_0000);
      n += 102;
    end
    wait_fault(400, w);
    n += w;
    check(n >= 512 && n <= 530, "R5 bad commands ignored", n, 514);

    // R6: off switch
    do_reset();
    wr(4'h4, 32'h0FFF_5000);
    repeat (500) @(negedge clk);
    wr(4'h0, 32'hA500_0001);
    repeat (1500) @(negedge clk);
    check(!saw, "R6 off: no pulse", saw, 0);
    rd(4'h8, d); check(d == 0, "R6 off: no status", d, 0);

    // R7: reset enable clear
    do_reset();
    wr(4'h4, 32'h0FFF_0000);
    repeat (400) @(negedge clk);
    check(!saw, "R7 no pulse without enable", saw, 0);
    rd(4'h8, d); check(d == 1, "R7 status still set", d, 1);

    // R9: debug halt
    do_reset();
    dbg_halt = 1'b1;
    wr(4'h4, 32'h0FFF_9001);
    repeat (1000) @(negedge clk);
    check(!saw, "R9 frozen while halted", saw, 0);
    dbg_halt = 1'b0;
    wait_fault(600, n);
    check(n >= 250 && n <= 270, "R9 resumes after halt", n, 256);

    // R10: narrow window (window 2, T=3)
    do_reset();
    wr(4'h4, 32'h0002_1003);
    for (int k = 0; k < 6; k++) begin
      repeat (298) @(negedge clk);
      wr(4'h0, 32'hA500_0001);
    end
    check(!saw, "R10 in-window restarts accepted", saw, 0);
    rd(4'h8, d); check(d == 0, "R10 no error in window", d, 0);
    wr(4'h0, 32'hA500_0001);
    wr(4'h0, 32'hA500_0001);
    wait_fault(10, n);
    check(wdt_rst_sys && n <= 3, "R10 early restart faults", n, 2);
    rd(4'h8, d); check(d == 2, "R10 error flag", d, 2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule